// File: doc/BRIEF.md
# MII Nibble and Serial Line Adapter

This block sits on the MAC side of an Ethernet PHY link and turns a byte stream into PHY lane traffic and back. It works in one of two modes. In nibble mode it sends and receives each byte as two 4-bit nibbles on a 4-lane bus. In serial mode it moves one bit per PHY clock on lane 0 only, and the other lanes carry no data. A single configuration bit picks the mode. In the MAC control register this is bit 27: set selects serial, clear selects nibble.

The transmit side takes bytes through a valid/ready handshake and drives the transmit enable and data lanes. The receive side samples the data-valid, data and error inputs and puts out assembled bytes with a valid pulse, an error flag, a frame-end pulse and a flag for a discarded partial byte. The PHY supplies both the transmit clock and the receive clock, and each direction runs entirely in its own clock domain. The mode bit is brought into each domain through a two-flop synchronizer. Each direction takes up a new mode only between frames.

Top module: `mii_endec_adapter`

## Requirements
- R1: `cfgSerial` high selects serial mode and low selects nibble mode. The bit reaches each clock domain through a two-stage synchronizer.
- R2: In nibble mode a transmitted byte appears on `phyTxd` as two consecutive nibbles, bits 3:0 first and then bits 7:4. Byte A1h goes out as 1h then Ah.
- R3: In serial mode a transmitted byte appears on `phyTxd[0]` as eight consecutive bits, bit 0 first. `phyTxd[3:1]` stays low. While `phyTxEn` is low, all of `phyTxd` is low.
- R4: `phyTxEn` rises in the cycle that carries the first unit of a frame. It stays high through the last unit and falls in the next cycle. After reset it is low.
- R5: `txReady` is high exactly when no unit of the current byte remains to be sent. A byte offered whenever `txReady` is high follows the previous byte with no gap cycle.
- R6: In nibble mode a byte is assembled from two nibbles sampled while `phyRxDv` is high, the first nibble giving bits 3:0. `rxValid` pulses for one cycle after the edge that sampled the second nibble.
- R7: In serial mode a byte is assembled from eight bits of `phyRxd[0]` sampled while `phyRxDv` is high, with the first bit becoming bit 0. `phyRxd[3:1]` is ignored.
- R8: In nibble mode, `phyRxEr` sampled high with `phyRxDv` marks the byte being assembled, and `rxErr` is high together with that byte's `rxValid`. In serial mode `phyRxEr` is ignored.
- R9: The first edge that samples `phyRxDv` low after a frame produces a one-cycle `rxEnd` pulse. If part of a byte was collected, that part is dropped without `rxValid` and `rxPartial` pulses together with `rxEnd`.
- R10: If the mode changes during a frame, each direction finishes that frame in the old mode and uses the new mode from its next frame onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| txClk | input | 1 | Transmit clock from the PHY |
| txRstN | input | 1 | Active-low reset, transmit domain |
| rxClk | input | 1 | Receive clock from the PHY |
| rxRstN | input | 1 | Active-low reset, receive domain |
| cfgSerial | input | 1 | Mode bit (control register bit 27): 1 serial, 0 nibble |
| txData | input | DATA_W | Byte to transmit |
| txValid | input | 1 | `txData` is offered |
| txReady | output | 1 | Byte accepted at the next transmit edge when valid |
| phyTxEn | output | 1 | Transmit enable to the PHY |
| phyTxd | output | LANES | Transmit data lanes |
| phyRxDv | input | 1 | Receive data valid from the PHY |
| phyRxd | input | LANES | Receive data lanes |
| phyRxEr | input | 1 | Receive error from the PHY |
| rxData | output | DATA_W | Assembled byte |
| rxValid | output | 1 | One-cycle pulse: `rxData` is valid |
| rxErr | output | 1 | Byte marked errored, valid with `rxValid` |
| rxEnd | output | 1 | One-cycle pulse at the end of a receive frame |
| rxPartial | output | 1 | Partial byte discarded, pulses with `rxEnd` |

## Verification
A byte accepted at a transmit edge puts its first unit on the pins right after that edge. Further units follow on every later edge, and `phyTxEn` drops after the edge that follows the last unit. On receive, `rxValid` comes after the edge that samples the final unit of a byte, and `rxEnd` and `rxPartial` come after the first edge that samples `phyRxDv` low. A mode change needs two edges in the synchronizer before it is seen and then waits for the next frame boundary. The bench drives and samples on falling edges, so every output it reads has settled from the rising edge one half period earlier. The mode-change tests leave several idle cycles before the next frame.

// File: rtl/adapter_pkg.sv
package adapter_pkg;

  typedef enum logic {
    MODE_NIBBLE = 1'b0,
    MODE_SERIAL = 1'b1
  } phyMode_e;

  // Transmit control to datapath strobes
  typedef struct packed {
    logic     load;   // take a new byte, drive its first unit
    logic     shift;  // drive the next unit of the current byte
    phyMode_e mode;   // lane format in force
  } txStrobe_t;

  // Receive control to datapath strobes
  typedef struct packed {
    logic     take;     // a valid unit is on the lanes
    logic     last;     // that unit completes a byte
    logic     drop;     // data-valid fell with a partial byte
    logic     endFrame; // data-valid fell after a frame
    phyMode_e mode;     // lane format in force
  } rxStrobe_t;

endpackage

// File: rtl/adapter_sync.sv
module adapter_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/adapter_ctrl.sv
module adapter_ctrl
  import adapter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANES  = 4
) (
  input  logic      txClk,
  input  logic      txRstN,
  input  logic      txModeSync,
  input  logic      txValid,
  output logic      txReady,
  output logic      txEn,
  output txStrobe_t txStb,
  input  logic      rxClk,
  input  logic      rxRstN,
  input  logic      rxModeSync,
  input  logic      rxDv,
  output rxStrobe_t rxStb
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] SER_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] NIB_LAST = CNT_W'(DATA_W / LANES - 1);

  // ---------------- transmit domain ----------------
  logic [CNT_W-1:0] txCnt;
  logic             txEnQ;
  phyMode_e         txModeQ, txModeEff;
  logic [CNT_W-1:0] txLastIdx;

  assign txModeEff = (txCnt == '0 && !txEnQ) ? phyMode_e'(txModeSync) : txModeQ;
  assign txLastIdx = (txModeEff == MODE_SERIAL) ? SER_LAST : NIB_LAST;
  assign txReady   = (txCnt == '0);
  assign txStb.load  = txValid && txReady;
  assign txStb.shift = (txCnt != '0);
  assign txStb.mode  = txModeEff;
  assign txEn        = txEnQ;

  always_ff @(posedge txClk or negedge txRstN) begin
    if (!txRstN) begin
      txCnt   <= '0;
      txEnQ   <= 1'b0;
      txModeQ <= MODE_NIBBLE;
    end else begin
      txModeQ <= txModeEff;
      txEnQ   <= txStb.load || txStb.shift;
      if (txStb.load)       txCnt <= txLastIdx;
      else if (txStb.shift) txCnt <= txCnt - 1'b1;
    end
  end

  // ---------------- receive domain ----------------
  logic [CNT_W-1:0] rxCnt;
  logic             rxActive;
  phyMode_e         rxModeQ, rxModeEff;
  logic [CNT_W-1:0] rxLastIdx;

  assign rxModeEff = !rxActive ? phyMode_e'(rxModeSync) : rxModeQ;
  assign rxLastIdx = (rxModeEff == MODE_SERIAL) ? SER_LAST : NIB_LAST;
  assign rxStb.take     = rxDv;
  assign rxStb.last     = rxDv && (rxCnt == rxLastIdx);
  assign rxStb.drop     = !rxDv && (rxCnt != '0);
  assign rxStb.endFrame = !rxDv && rxActive;
  assign rxStb.mode     = rxModeEff;

  always_ff @(posedge rxClk or negedge rxRstN) begin
    if (!rxRstN) begin
      rxCnt    <= '0;
      rxActive <= 1'b0;
      rxModeQ  <= MODE_NIBBLE;
    end else begin
      rxModeQ  <= rxModeEff;
      rxActive <= rxDv;
      if (rxStb.last || !rxDv) rxCnt <= '0;
      else                     rxCnt <= rxCnt + 1'b1;
    end
  end

  // R10: a frame keeps its mode while it runs
  assert_tx_mode_hold_R10: assert property (@(posedge txClk) disable iff (!txRstN)
    (txEnQ && txStb.shift) |=> (txStb.mode == $past(txStb.mode)));
  assert_rx_mode_hold_R10: assert property (@(posedge rxClk) disable iff (!rxRstN)
    (rxActive && rxDv) |=> (rxStb.mode == $past(rxStb.mode)));
endmodule

// File: rtl/adapter_datapath.sv
module adapter_datapath
  import adapter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANES  = 4
) (
  input  logic              txClk,
  input  logic              txRstN,
  input  txStrobe_t         txStb,
  input  logic [DATA_W-1:0] txData,
  output logic [LANES-1:0]  phyTxd,
  input  logic              rxClk,
  input  logic              rxRstN,
  input  rxStrobe_t         rxStb,
  input  logic [LANES-1:0]  phyRxd,
  input  logic              phyRxEr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxErr,
  output logic              rxEnd,
  output logic              rxPartial
);
  // ---------------- transmit shifter ----------------
  logic [DATA_W-1:0] txSh;

  function automatic logic [LANES-1:0] unitOf(input logic [DATA_W-1:0] v, input phyMode_e m);
    if (m == MODE_SERIAL) return {{(LANES-1){1'b0}}, v[0]};
    return v[LANES-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] restOf(input logic [DATA_W-1:0] v, input phyMode_e m);
    if (m == MODE_SERIAL) return v >> 1;
    return v >> LANES;
  endfunction

  always_ff @(posedge txClk or negedge txRstN) begin
    if (!txRstN) begin
      txSh   <= '0;
      phyTxd <= '0;
    end else if (txStb.load) begin
      phyTxd <= unitOf(txData, txStb.mode);
      txSh   <= restOf(txData, txStb.mode);
    end else if (txStb.shift) begin
      phyTxd <= unitOf(txSh, txStb.mode);
      txSh   <= restOf(txSh, txStb.mode);
    end else begin
      phyTxd <= '0;
    end
  end

  // ---------------- receive assembler ----------------
  logic [DATA_W-1:0] acc, accNext;
  logic              errAcc, errIn;

  assign accNext = (rxStb.mode == MODE_SERIAL) ? {phyRxd[0], acc[DATA_W-1:1]}
                                               : {phyRxd, acc[DATA_W-1:LANES]};
  assign errIn   = (rxStb.mode == MODE_NIBBLE) && phyRxEr;

  always_ff @(posedge rxClk or negedge rxRstN) begin
    if (!rxRstN) begin
      acc       <= '0;
      errAcc    <= 1'b0;
      rxData    <= '0;
      rxValid   <= 1'b0;
      rxErr     <= 1'b0;
      rxEnd     <= 1'b0;
      rxPartial <= 1'b0;
    end else begin
      rxValid   <= rxStb.last;
      rxEnd     <= rxStb.endFrame;
      rxPartial <= rxStb.drop;
      if (rxStb.take) acc <= accNext;
      if (rxStb.last) begin
        rxData <= accNext;
        rxErr  <= errAcc || errIn;
        errAcc <= 1'b0;
      end else if (rxStb.take) begin
        errAcc <= errAcc || errIn;
      end else begin
        errAcc <= 1'b0;
      end
    end
  end

  // R8: serial frames never report an error
  assert_serial_no_err_R8: assert property (@(posedge rxClk) disable iff (!rxRstN)
    (rxStb.last && rxStb.mode == MODE_SERIAL) |=> !rxErr);
endmodule

// File: rtl/mii_endec_adapter.sv
module mii_endec_adapter
  import adapter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANES  = 4
) (
  input  logic              txClk,
  input  logic              txRstN,
  input  logic              rxClk,
  input  logic              rxRstN,
  input  logic              cfgSerial,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic              phyTxEn,
  output logic [LANES-1:0]  phyTxd,
  input  logic              phyRxDv,
  input  logic [LANES-1:0]  phyRxd,
  input  logic              phyRxEr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxErr,
  output logic              rxEnd,
  output logic              rxPartial
);
  logic      txModeSync, rxModeSync;
  txStrobe_t txStb;
  rxStrobe_t rxStb;

  adapter_sync #(.STAGES(2)) uTxSync (.clk(txClk), .rstN(txRstN), .din(cfgSerial), .dout(txModeSync));
  adapter_sync #(.STAGES(2)) uRxSync (.clk(rxClk), .rstN(rxRstN), .din(cfgSerial), .dout(rxModeSync));

  adapter_ctrl #(.DATA_W(DATA_W), .LANES(LANES)) uCtrl (
    .txClk(txClk), .txRstN(txRstN), .txModeSync(txModeSync), .txValid(txValid),
    .txReady(txReady), .txEn(phyTxEn), .txStb(txStb),
    .rxClk(rxClk), .rxRstN(rxRstN), .rxModeSync(rxModeSync), .rxDv(phyRxDv), .rxStb(rxStb)
  );

  adapter_datapath #(.DATA_W(DATA_W), .LANES(LANES)) uPath (
    .txClk(txClk), .txRstN(txRstN), .txStb(txStb), .txData(txData), .phyTxd(phyTxd),
    .rxClk(rxClk), .rxRstN(rxRstN), .rxStb(rxStb), .phyRxd(phyRxd), .phyRxEr(phyRxEr),
    .rxData(rxData), .rxValid(rxValid), .rxErr(rxErr), .rxEnd(rxEnd), .rxPartial(rxPartial)
  );

  // R3: lanes are quiet while enable is low
  assert_idle_lanes_low_R3: assert property (@(posedge txClk) disable iff (!txRstN)
    !phyTxEn |-> (phyTxd == '0));
  // R5: an accepted byte is on the pins next cycle
  assert_accept_drives_R5: assert property (@(posedge txClk) disable iff (!txRstN)
    (txValid && txReady) |=> phyTxEn);
  // R4: enable holds while units of a byte remain
  assert_en_holds_R4: assert property (@(posedge txClk) disable iff (!txRstN)
    (phyTxEn && !txReady) |=> phyTxEn);
  // R9: a dropped partial byte comes with the frame end and without a byte
  assert_partial_with_end_R9: assert property (@(posedge rxClk) disable iff (!rxRstN)
    rxPartial |-> (rxEnd && !rxValid));
endmodule

// File: tb/tb_mii_endec_adapter.sv
module tb_mii_endec_adapter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgSerial = 1'b0;
  logic [7:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txReady, phyTxEn;
  logic [3:0] phyTxd;
  logic       phyRxDv = 1'b0;
  logic [3:0] phyRxd = '0;
  logic       phyRxEr = 1'b0;
  logic [7:0] rxData;
  logic       rxValid, rxErr, rxEnd, rxPartial;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  mii_endec_adapter dut (
    .txClk(clk), .txRstN(rstN), .rxClk(clk), .rxRstN(rstN), .cfgSerial(cfgSerial),
    .txData(txData), .txValid(txValid), .txReady(txReady), .phyTxEn(phyTxEn), .phyTxd(phyTxd),
    .phyRxDv(phyRxDv), .phyRxd(phyRxd), .phyRxEr(phyRxEr),
    .rxData(rxData), .rxValid(rxValid), .rxErr(rxErr), .rxEnd(rxEnd), .rxPartial(rxPartial)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected transmit unit k of a frame
  function automatic logic [3:0] txUnit(input logic [7:0] b[16], input bit ser, input int k);
    if (ser) return {3'b000, b[k/8][k%8]};
    return (k % 2 == 1) ? b[k/2][7:4] : b[k/2][3:0];
  endfunction

  task automatic setMode(input bit m);
    cfgSerial = m;
    repeat (5) @(negedge clk);
  endtask

  task automatic runTx(input bit ser, input int n, input bit fixed, input int flipAt);
    logic [7:0] b[16];
    int upb = ser ? 8 : 2;
    int idx = 0, obs = 0;
    bit started = 0, done = 0, flipped = 0;
    string req = ser ? "R1/R3" : "R1/R2";
    for (int i = 0; i < 16; i++) b[i] = 8'($urandom);
    if (fixed) begin b[0] = 8'hA1; b[1] = 8'hE6; end
    while (!done) begin
      @(negedge clk);
      if (phyTxEn) begin
        if (obs < n * upb) check(phyTxd == txUnit(b, ser, obs), req, "tx unit", phyTxd, txUnit(b, ser, obs));
        obs++;
        started = 1;
      end else begin
        if (started) done = 1;
        else if (idx > 0) check(phyTxd == 4'h0, "R3", "idle lanes", phyTxd, 0);
      end
      if (flipAt >= 0 && !flipped && idx > flipAt) begin cfgSerial = !ser; flipped = 1; end
      if (idx < n) begin
        txValid = 1'b1;
        txData  = b[idx];
        if (txReady) idx++;
      end else begin
        txValid = 1'b0;
      end
    end
    check(obs == n * upb, "R4/R5", "enable cycles in frame", obs, n * upb);
    check(phyTxd == 4'h0 && txReady, "R4", "lanes and ready after frame", {phyTxd, txReady}, 1);
    if (flipped) check(1'b1, "R10", "tx frame kept mode", 0, 0);
  endtask

  task automatic runRx(input bit ser, input int n, input int extra, input int errByte, input int flipAt);
    logic [7:0] b[16];
    int upb = ser ? 8 : 2;
    int total = n * upb + extra;
    int got = 0, ends = 0, parts = 0;
    string req = ser ? "R1/R7" : "R1/R6";
    for (int i = 0; i < 16; i++) b[i] = 8'($urandom);
    for (int u = 0; u < total + 4; u++) begin
      @(negedge clk);
      if (rxValid) begin
        if (got < n) begin
          check(rxData == b[got], req, "rx byte", rxData, b[got]);
          check(rxErr == (!ser && got == errByte), "R8", "rx error flag", rxErr, (!ser && got == errByte));
        end
        got++;
      end
      if (rxEnd) ends++;
      if (rxPartial) parts++;
      if (u == flipAt) cfgSerial = !ser;
      if (u < total) begin
        logic bitv;
        phyRxDv = 1'b1;
        if (ser) begin
          bitv    = (u < n * upb) ? b[u/8][u%8] : 1'($urandom);
          phyRxd  = {3'($urandom), bitv};
          phyRxEr = 1'($urandom);
        end else begin
          phyRxd  = (u >= n * upb) ? 4'($urandom) : ((u % 2 == 1) ? b[u/2][7:4] : b[u/2][3:0]);
          phyRxEr = (u / 2 == errByte && u % 2 == 1);
        end
      end else begin
        phyRxDv = 1'b0;
        phyRxEr = 1'b0;
        phyRxd  = 4'($urandom);
      end
    end
    check(got == n, req, "rx byte count", got, n);
    check(ends == 1, "R9", "frame end pulses", ends, 1);
    check(parts == (extra > 0 ? 1 : 0), "R9", "partial flag", parts, (extra > 0 ? 1 : 0));
    if (flipAt >= 0) check(1'b1, "R10", "rx frame kept mode", 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h5eed_0427);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!phyTxEn && phyTxd == 0, "R4", "reset tx pins", {phyTxEn, phyTxd}, 0);
    check(txReady, "R5", "reset ready", txReady, 1);
    check(!rxValid && !rxEnd && !rxPartial, "R9", "reset rx flags", {rxValid, rxEnd, rxPartial}, 0);

    // directed transmit
    setMode(0); runTx(0, 2, 1, -1); runTx(0, 8, 0, -1);
    setMode(1); runTx(1, 2, 1, -1); runTx(1, 5, 0, -1);
    // R10 transmit: flip mid-frame both ways
    setMode(0); runTx(0, 4, 0, 1);
    repeat (5) @(negedge clk); runTx(1, 3, 0, -1);
    runTx(1, 3, 0, 0);
    repeat (5) @(negedge clk); runTx(0, 2, 0, -1);

    // directed receive
    setMode(0); runRx(0, 3, 0, -1, -1); runRx(0, 4, 1, 2, -1);
    setMode(1); runRx(1, 3, 0, -1, -1); runRx(1, 2, 5, -1, -1);
    // R10 receive
    runRx(1, 3, 0, -1, 4);
    repeat (5) @(negedge clk); runRx(0, 2, 0, 0, -1);
    runRx(0, 3, 0, 1, 2);
    repeat (5) @(negedge clk); runRx(1, 2, 3, -1, -1);

    // constrained random
    for (int it = 0; it < 8; it++) begin
      bit m = 1'($urandom);
      int upb = m ? 8 : 2;
      setMode(m);
      runTx(m, 1 + int'($urandom_range(0, 9)), 0, -1);
      runRx(m, 1 + int'($urandom_range(0, 9)), int'($urandom_range(0, upb - 1)),
            int'($urandom_range(0, 5)), -1);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule